// File: doc/BRIEF.md
# Mode-Gated Extension Instruction Enable Unit

This unit sits next to an instruction decoder and rules, for each retiring instruction, whether it may execute or must raise an illegal-instruction trap. The decision rests on a mode register. That register holds persistent enable flags, a binary custom-mode selector, a three-bit compatibility field that caps the ISA version level, and a countdown. The countdown switches a burst extension mode on for a set number of retired instructions. When the count runs out, the mode switches off with no further write.

The decoder presents the class of the instruction, a selector index, a version level, a flag for a non-sequential PC change, and the privilege level. A mode-write instruction carries its new register value on `wr_data`. Trap entry saves the whole mode state and drops the live state to base mode. Trap return restores the saved state exactly.

Top module: `mode_gate_unit`

## Requirements
- R1: Reset (synchronous, active low) clears the whole mode register, so `rd_data` reads zero. Zero is the fully base-compliant mode.
- R2: A class 1 (official) instruction traps unless official flag bit `iss_sel` (bits [3:0]) is set. A class 2 (experimental) instruction traps unless experimental flag bit `iss_sel` (bits [7:4]) is set.
- R3: The custom selector is a binary field at bits [10:8], and zero means no custom mode. A class 3 (custom) instruction is allowed only when the selector is nonzero and equals `iss_sel`.
- R4: The countdown is at bits [23:18]. A class 4 (burst) instruction is allowed only while the countdown is nonzero. Each allowed instruction other than a mode write decrements a nonzero countdown by one. The mode write that loads the countdown is not counted.
- R5: Any instruction presented with `iss_jump` high while the countdown is nonzero traps. With the countdown at zero, `iss_jump` has no effect on the decision.
- R6: The compatibility field is at bits [13:11]. When it is zero, version levels 0 to 3 are all allowed. Otherwise the lowest set bit k caps the level, and a class 5 (versioned) instruction with `iss_ver` > k traps.
- R7: The official flags and the compatibility field are privileged. A class 6 (mode write) issued with `priv_sup` low that would change any privileged bit traps and leaves the register unchanged. At user level, the other fields can be written freely.
- R8: A mode write that sets any reserved bit (bits [17:14]) traps and leaves the register unchanged.
- R9: `trap_enter` saves the full register, countdown included, and clears the live register to zero. `trap_return` restores the saved value exactly.
- R10: Class codes are: 0 base, 1 official, 2 experimental, 3 custom, 4 burst, 5 versioned, 6 mode write, 7 undefined. Class 7 always traps. The decision uses the state before the instruction retires. A trapped instruction changes no state. `allow` and `trap` are both low while `iss_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | An instruction retires this cycle |
| iss_class | input | 3 | Instruction class code |
| iss_sel | input | SEL_W | Flag index or custom mode number |
| iss_ver | input | 2 | ISA version level the instruction needs |
| iss_jump | input | 1 | Instruction changes the PC non-sequentially |
| priv_sup | input | 1 | Supervisor privilege level |
| wr_data | input | MW | New register value carried by a mode write |
| trap_enter | input | 1 | Trap entry strobe (save and clear) |
| trap_return | input | 1 | Trap return strobe (restore) |
| rd_data | output | MW | Current mode register |
| allow | output | 1 | Instruction may execute |
| trap | output | 1 | Instruction raises an illegal-instruction trap |

## Verification
The bench builds the unit with its default parameters: four official flags, four experimental flags, a three-bit custom selector, four reserved bits and a six-bit countdown. With these values every field fits in a 24-bit word, so each expected register value is one short hex constant. A countdown of two or three runs out within a few table rows, which brings the self-clearing burst mode and the jump-during-countdown trap within reach. A custom selector of three bits makes `iss_sel` wide enough to name a custom mode that differs from the active one.

// File: rtl/mode_gate_pkg.sv
// Shared definitions for the mode-gated enable unit.
// Assumes: class codes are fixed by the decoder contract.
package mode_gate_pkg;

    typedef enum logic [2:0] {
        CLS_BASE      = 3'd0,
        CLS_OFFICIAL  = 3'd1,
        CLS_EXPER     = 3'd2,
        CLS_CUSTOM    = 3'd3,
        CLS_BURST     = 3'd4,
        CLS_VERSIONED = 3'd5,
        CLS_MODE_WR   = 3'd6,
        CLS_UNDEF     = 3'd7
    } iclass_e;

    localparam int CMP_W = 3;   // compatibility field width
    localparam int VER_W = 2;   // version level width

endpackage

// File: rtl/mg_compat_limit.sv
// Turns the compatibility field into the highest allowed version level.
// Assumes: zero field means no cap; otherwise the lowest set bit wins.
module mg_compat_limit
    import mode_gate_pkg::*;
(
    input  logic [CMP_W-1:0] cmp,
    output logic [VER_W-1:0] lvl
);

    // Scan from the top bit down so the lowest set bit is the last to assign.
    always_comb begin
        lvl = VER_W'(CMP_W);
        for (int k = CMP_W - 1; k >= 0; k--) begin
            if (cmp[k]) lvl = VER_W'(k);
        end
    end

endmodule

// File: rtl/mg_decide.sv
// Combinational allow/trap decision for the presented instruction.
// Assumes: cur holds the state before this instruction retires.
module mg_decide
    import mode_gate_pkg::*;
#(
    parameter int OFF_W = 4,
    parameter int EXP_W = 4,
    parameter int CUS_W = 3,
    parameter int RSV_W = 4,
    parameter int CNT_W = 6,
    parameter int SEL_W = 3,
    localparam int MW     = OFF_W + EXP_W + CUS_W + CMP_W + RSV_W + CNT_W,
    localparam int EXP_LO = OFF_W,
    localparam int CUS_LO = EXP_LO + EXP_W,
    localparam int CMP_LO = CUS_LO + CUS_W,
    localparam int RSV_LO = CMP_LO + CMP_W,
    localparam int CNT_LO = RSV_LO + RSV_W
) (
    input  logic [MW-1:0]    cur,
    input  logic             iss_valid,
    input  logic [2:0]       iss_class,
    input  logic [SEL_W-1:0] iss_sel,
    input  logic [VER_W-1:0] iss_ver,
    input  logic             iss_jump,
    input  logic             priv_sup,
    input  logic [MW-1:0]    wr_data,
    output logic             allow,
    output logic             trap,
    output logic             wr_ok,
    output logic             adv
);

    localparam logic [MW-1:0] ONE = {{(MW-1){1'b0}}, 1'b1};
    localparam logic [MW-1:0] PRIV_MASK = ((ONE << OFF_W) - ONE)
                                        | (((ONE << CMP_W) - ONE) << CMP_LO);
    localparam logic [MW-1:0] RSV_MASK  = ((ONE << RSV_W) - ONE) << RSV_LO;

    logic [OFF_W-1:0] off_f;
    logic [EXP_W-1:0] exp_f;
    logic [CUS_W-1:0] cus_f;
    logic [CMP_W-1:0] cmp_f;
    logic [CNT_W-1:0] cnt_f;
    logic [VER_W-1:0] lvl;
    logic             off_hit, exp_hit, cus_hit, cnt_live;
    logic             priv_change, rsv_set, cls_bad, illegal;
    iclass_e          cls;

    assign off_f = cur[OFF_W-1:0];
    assign exp_f = cur[EXP_LO +: EXP_W];
    assign cus_f = cur[CUS_LO +: CUS_W];
    assign cmp_f = cur[CMP_LO +: CMP_W];
    assign cnt_f = cur[CNT_LO +: CNT_W];
    assign cls   = iclass_e'(iss_class);

    mg_compat_limit u_lim (
        .cmp (cmp_f),
        .lvl (lvl)
    );

    // Look up the official flag named by the selector.
    always_comb begin
        off_hit = 1'b0;
        for (int i = 0; i < OFF_W; i++) begin
            if (iss_sel == SEL_W'(i)) off_hit = off_f[i];
        end
    end

    // Look up the experimental flag named by the selector.
    always_comb begin
        exp_hit = 1'b0;
        for (int i = 0; i < EXP_W; i++) begin
            if (iss_sel == SEL_W'(i)) exp_hit = exp_f[i];
        end
    end

    assign cus_hit     = (cus_f != '0) && (SEL_W'(cus_f) == iss_sel);
    assign cnt_live    = (cnt_f != '0);
    assign priv_change = ((wr_data ^ cur) & PRIV_MASK) != '0;
    assign rsv_set     = (wr_data & RSV_MASK) != '0;

    // Class-specific legality check.
    always_comb begin
        unique case (cls)
            CLS_BASE:      cls_bad = 1'b0;
            CLS_OFFICIAL:  cls_bad = !off_hit;
            CLS_EXPER:     cls_bad = !exp_hit;
            CLS_CUSTOM:    cls_bad = !cus_hit;
            CLS_BURST:     cls_bad = !cnt_live;
            CLS_VERSIONED: cls_bad = (iss_ver > lvl);
            CLS_MODE_WR:   cls_bad = (!priv_sup && priv_change) || rsv_set;
            default:       cls_bad = 1'b1;
        endcase
    end

    assign illegal = cls_bad || (iss_jump && cnt_live);
    assign trap    = iss_valid && illegal;
    assign allow   = iss_valid && !illegal;
    assign wr_ok   = allow && (cls == CLS_MODE_WR);
    assign adv     = allow && (cls != CLS_MODE_WR);

endmodule

// File: rtl/mg_state.sv
// Mode register, its trap-save copy and the countdown update.
// Assumes: trap strobes take priority over a retiring instruction.
module mg_state #(
    parameter int MW     = 24,
    parameter int CNT_W  = 6,
    parameter int CNT_LO = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trap_enter,
    input  logic          trap_return,
    input  logic          wr_ok,
    input  logic          adv,
    input  logic [MW-1:0] wr_data,
    output logic [MW-1:0] cur
);

    logic [MW-1:0]    saved;
    logic [CNT_W-1:0] cnt_now;

    assign cnt_now = cur[CNT_LO +: CNT_W];

    // Live register: reset, save/clear, restore, write, or count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (trap_enter) begin
            cur <= '0;
        end else if (trap_return) begin
            cur <= saved;
        end else if (wr_ok) begin
            cur <= wr_data;
        end else if (adv && (cnt_now != '0)) begin
            cur[CNT_LO +: CNT_W] <= cnt_now - CNT_W'(1);
        end
    end

    // Save copy: captured on trap entry only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saved <= '0;
        end else if (trap_enter) begin
            saved <= cur;
        end
    end

endmodule

// File: rtl/mode_gate_unit.sv
// Top of the mode-gated instruction enable unit.
// Assumes: one retiring instruction per cycle at most, decoder-supplied class.
module mode_gate_unit
    import mode_gate_pkg::*;
#(
    parameter int OFF_W = 4,
    parameter int EXP_W = 4,
    parameter int CUS_W = 3,
    parameter int RSV_W = 4,
    parameter int CNT_W = 6,
    localparam int MW    = OFF_W + EXP_W + CUS_W + CMP_W + RSV_W + CNT_W,
    localparam int SEL_N = (OFF_W > EXP_W)
                         ? ((OFF_W > (1 << CUS_W)) ? OFF_W : (1 << CUS_W))
                         : ((EXP_W > (1 << CUS_W)) ? EXP_W : (1 << CUS_W)),
    localparam int SEL_W = (SEL_N > 1) ? $clog2(SEL_N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    input  logic [2:0]       iss_class,
    input  logic [SEL_W-1:0] iss_sel,
    input  logic [VER_W-1:0] iss_ver,
    input  logic             iss_jump,
    input  logic             priv_sup,
    input  logic [MW-1:0]    wr_data,
    input  logic             trap_enter,
    input  logic             trap_return,
    output logic [MW-1:0]    rd_data,
    output logic             allow,
    output logic             trap
);

    localparam int CNT_LO = OFF_W + EXP_W + CUS_W + CMP_W + RSV_W;

    logic [MW-1:0] cur;
    logic          wr_ok, adv;

    mg_decide #(
        .OFF_W (OFF_W), .EXP_W (EXP_W), .CUS_W (CUS_W),
        .RSV_W (RSV_W), .CNT_W (CNT_W), .SEL_W (SEL_W)
    ) u_dec (
        .cur       (cur),
        .iss_valid (iss_valid),
        .iss_class (iss_class),
        .iss_sel   (iss_sel),
        .iss_ver   (iss_ver),
        .iss_jump  (iss_jump),
        .priv_sup  (priv_sup),
        .wr_data   (wr_data),
        .allow     (allow),
        .trap      (trap),
        .wr_ok     (wr_ok),
        .adv       (adv)
    );

    mg_state #(
        .MW (MW), .CNT_W (CNT_W), .CNT_LO (CNT_LO)
    ) u_st (
        .clk         (clk),
        .rst_n       (rst_n),
        .trap_enter  (trap_enter),
        .trap_return (trap_return),
        .wr_ok       (wr_ok),
        .adv         (adv),
        .wr_data     (wr_data),
        .cur         (cur)
    );

    assign rd_data = cur;

endmodule

// File: rtl/mode_gate_unit_chk.sv
// Property checker for mode_gate_unit, attached by bind.
// Assumes: default field layout offsets derived from the same parameters.
module mode_gate_unit_chk #(
    parameter int MW     = 24,
    parameter int CNT_W  = 6,
    parameter int CNT_LO = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          iss_valid,
    input logic [2:0]    iss_class,
    input logic          iss_jump,
    input logic          trap_enter,
    input logic          trap_return,
    input logic [MW-1:0] rd_data,
    input logic          allow,
    input logic          trap
);

    logic             after_rst = 1'b0;
    logic [CNT_W-1:0] cnt_rd;
    logic             no_strobe;

    assign cnt_rd    = rd_data[CNT_LO +: CNT_W];
    assign no_strobe = !trap_enter && !trap_return;

    // Marks the cycle right after a reset cycle.
    always_ff @(posedge clk) after_rst <= !rst_n;

    p_reset_clear_r1: assert property (@(posedge clk)
        after_rst |-> (rd_data == '0));

    p_one_verdict_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(allow && trap) && (iss_valid || (!allow && !trap)));

    p_trap_no_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (trap && no_strobe) |=> $stable(rd_data));

    p_burst_dead_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_class == 3'd4 && cnt_rd == '0) |-> trap);

    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (allow && iss_class != 3'd6 && cnt_rd != '0 && no_strobe)
        |=> (cnt_rd == $past(cnt_rd) - CNT_W'(1)));

    p_jump_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_jump && cnt_rd != '0) |-> trap);

    p_enter_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_enter |=> (rd_data == '0));

endmodule

bind mode_gate_unit mode_gate_unit_chk #(
    .MW (MW), .CNT_W (CNT_W), .CNT_LO (CNT_LO)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .iss_valid   (iss_valid),
    .iss_class   (iss_class),
    .iss_jump    (iss_jump),
    .trap_enter  (trap_enter),
    .trap_return (trap_return),
    .rd_data     (rd_data),
    .allow       (allow),
    .trap        (trap)
);

// File: tb/test_mode_gate_unit.sv
// Self-checking bench: table walk, then directed trap/reset cases.
module test_mode_gate_unit;

    localparam int CLK_PERIOD = 10;
    localparam int MW = 24;
    localparam int NV = 29;

    // Entry: class, sel, ver, jump, sup, wdata, expected trap, expected register.
    localparam logic [58:0] TBL [0:NV-1] = '{
        {3'd1, 3'd0, 2'd0, 1'b0, 1'b0, 24'h000000, 1'b1, 24'h000000}, // R2
        {3'd6, 3'd0, 2'd0, 1'b0, 1'b0, 24'h000001, 1'b1, 24'h000000}, // R7
        {3'd6, 3'd0, 2'd0, 1'b0, 1'b1, 24'h000001, 1'b0, 24'h000001}, // R7
        {3'd1, 3'd0, 2'd0, 1'b0, 1'b0, 24'h000000, 1'b0, 24'h000001}, // R2
        {3'd1, 3'd1, 2'd0, 1'b0, 1'b0, 24'h000000, 1'b1, 24'h000001}, // R2
        {3'd6, 3'd0, 2'd0, 1'b0, 1'b0, 24'h000021, 1'b0, 24'h000021}, // R7
        {3'd2, 3'd1, 2'd0, 1'b0, 1'b0, 24'h000000, 1'b0, 24'h000021}, // R2
        {3'd2, 3'd0, 2'd0, 1'b0, 1'b0, 24'h000000, 1'b1, 24'h000021}, // R2
        {3'd3, 3'd3, 2'd0, 1'b0, 1'b0, 24'h000000, 1'b1, 24'h000021}, // R3
        {3'd6, 3'd0, 2'd0, 1'b0, 1'b0, 24'h000321, 1'b0, 24'h000321}, // R3
        {3'd3, 3'd3, 2'd0, 1'b0, 1'b0, 24'h000000, 1'b0, 24'h000321}, // R3
        {3'd3, 3'd2, 2'd0, 1'b0, 1'b0, 24'h000000, 1'b1, 24'h000321}, // R3
        {3'd5, 3'd0, 2'd3, 1'b0, 1'b0, 24'h000000, 1'b0, 24'h000321}, // R6
        {3'd6, 3'd0, 2'd0, 1'b0, 1'b1, 24'h001321, 1'b0, 24'h001321}, // R6
        {3'd5, 3'd0, 2'd1, 1'b0, 1'b0, 24'h000000, 1'b0, 24'h001321}, // R6
        {3'd5, 3'd0, 2'd2, 1'b0, 1'b0, 24'h000000, 1'b1, 24'h001321}, // R6
        {3'd6, 3'd0, 2'd0, 1'b0, 1'b1, 24'h005321, 1'b1, 24'h001321}, // R8
        {3'd4, 3'd0, 2'd0, 1'b0, 1'b0, 24'h000000, 1'b1, 24'h001321}, // R4
        {3'd6, 3'd0, 2'd0, 1'b0, 1'b0, 24'h081321, 1'b0, 24'h081321}, // R4
        {3'd4, 3'd0, 2'd0, 1'b0, 1'b0, 24'h000000, 1'b0, 24'h041321}, // R4
        {3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 24'h000000, 1'b0, 24'h001321}, // R4
        {3'd4, 3'd0, 2'd0, 1'b0, 1'b0, 24'h000000, 1'b1, 24'h001321}, // R4
        {3'd6, 3'd0, 2'd0, 1'b0, 1'b0, 24'h0C1321, 1'b0, 24'h0C1321}, // R4
        {3'd0, 3'd0, 2'd0, 1'b1, 1'b0, 24'h000000, 1'b1, 24'h0C1321}, // R5
        {3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 24'h000000, 1'b0, 24'h081321}, // R4
        {3'd7, 3'd0, 2'd0, 1'b0, 1'b1, 24'h000000, 1'b1, 24'h081321}, // R10
        {3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 24'h000000, 1'b0, 24'h041321}, // R4
        {3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 24'h000000, 1'b0, 24'h001321}, // R4
        {3'd0, 3'd0, 2'd0, 1'b1, 1'b0, 24'h000000, 1'b0, 24'h001321}  // R5
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 1'b0;
    logic [2:0]    iss_class = '0;
    logic [2:0]    iss_sel = '0;
    logic [1:0]    iss_ver = '0;
    logic          iss_jump = 1'b0;
    logic          priv_sup = 1'b0;
    logic [MW-1:0] wr_data = '0;
    logic          trap_enter = 1'b0;
    logic          trap_return = 1'b0;
    logic [MW-1:0] rd_data;
    logic          allow, trap;

    int n_cmp = 0;
    int n_bad = 0;
    logic done = 1'b0;

    mode_gate_unit i_mode_gate_unit (
        .clk (clk), .rst_n (rst_n), .iss_valid (iss_valid),
        .iss_class (iss_class), .iss_sel (iss_sel), .iss_ver (iss_ver),
        .iss_jump (iss_jump), .priv_sup (priv_sup), .wr_data (wr_data),
        .trap_enter (trap_enter), .trap_return (trap_return),
        .rd_data (rd_data), .allow (allow), .trap (trap)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [MW-1:0] act,
                         input logic [MW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one instruction, check the verdict before the edge, the register after.
    task automatic step(input string req, input logic [2:0] c, input logic [2:0] s,
                        input logic [1:0] v, input logic j, input logic sup,
                        input logic [MW-1:0] wd, input logic xt,
                        input logic [MW-1:0] xr);
        @(negedge clk);
        iss_valid = 1'b1; iss_class = c; iss_sel = s; iss_ver = v;
        iss_jump = j; priv_sup = sup; wr_data = wd;
        #1;
        check(req, MW'(trap), MW'(xt));
        check(req, MW'(allow), MW'(!xt));
        @(posedge clk);
        #1;
        iss_valid = 1'b0; iss_jump = 1'b0;
        check(req, rd_data, xr);
    endtask

    task automatic strobe(input logic ent, input logic ret);
        @(negedge clk);
        trap_enter = ent; trap_return = ret;
        @(posedge clk);
        #1;
        trap_enter = 1'b0; trap_return = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", rd_data, '0);
        check("R10", MW'({allow, trap}), '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step($sformatf("row%0d", i), TBL[i][58:56], TBL[i][55:53], TBL[i][52:51],
                 TBL[i][50], TBL[i][49], TBL[i][48:25], TBL[i][24], TBL[i][23:0]);
        end

        // R9: save with a live countdown, change state in the handler, restore.
        step("R9", 3'd6, 3'd0, 2'd0, 1'b0, 1'b0, 24'h0C1321, 1'b0, 24'h0C1321);
        strobe(1'b1, 1'b0);
        check("R9", rd_data, '0);
        step("R9", 3'd6, 3'd0, 2'd0, 1'b0, 1'b1, 24'h000002, 1'b0, 24'h000002);
        strobe(1'b0, 1'b1);
        check("R9", rd_data, 24'h0C1321);
        step("R4", 3'd4, 3'd0, 2'd0, 1'b0, 1'b0, 24'h0, 1'b0, 24'h081321);

        // R10: no verdict while nothing retires.
        @(negedge clk);
        iss_class = 3'd7;
        #1;
        check("R10", MW'({allow, trap}), '0);

        // R1: reset in mid-run clears the register.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        check("R1", rd_data, '0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule